// File: doc/BRIEF.md
# General-Purpose I/O Port with Atomic Output Updates

This block is one port of general-purpose pins, 32 by default, behind a simple memory-mapped register bus that uses 32-bit word accesses. It keeps an output data latch and a per-pin direction register, and it samples the pad input levels through a synchronizer. It drives the pad outputs from the latch and drives the per-pin output enables from the direction register.

Three alias registers change the output latch in one bus write. Each one sets, clears or inverts only the bits written as 1, so concurrent software agents never need a read-modify-write sequence. A read is captured on the clock edge where the read strobe is high, and the read data then holds until the next read.

Top module: `gpio_port`

## Requirements
- R1: While reset is asserted, and after it is released, the output latch, the direction register, `pad_out`, `pad_oe` and `bus_rdata` are all zero, so every pin starts as an input.
- R2: A write to byte offset 0x00 loads the output latch with `bus_wdata`. A read of 0x00 returns the latch.
- R3: A write to offset 0x04 sets each latch bit whose written bit is 1 and leaves the other bits unchanged.
- R4: A write to offset 0x08 clears each latch bit whose written bit is 1 and leaves the other bits unchanged.
- R5: A write to offset 0x0C inverts each latch bit whose written bit is 1 and leaves the other bits unchanged.
- R6: A read of offset 0x10 returns the pad levels through a two-flop synchronizer. A read captured at the first or second rising edge after a pad change returns the old level, and a read captured at the third edge returns the new level. A write to 0x10 changes nothing.
- R7: A write to offset 0x14 loads the direction register (1 = output, 0 = input). A read returns it, and `pad_oe` equals it from the edge of the write onward.
- R8: `pad_out` equals the output latch and changes only on a write to offsets 0x00, 0x04, 0x08 or 0x0C.
- R9: The set, clear and toggle aliases read as zero. Offsets 0x18 and 0x1C, and any address whose two low bits are not 00, read as zero, and writes to them change nothing.
- R10: `bus_rdata` is loaded on the rising edge where `bus_rd` is 1 and holds while `bus_rd` is 0. A read and a write to the same register in the same cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_wr | input | 1 | Write strobe, one write per cycle when high |
| bus_rd | input | 1 | Read strobe, data captured at the next rising edge |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | PIN_COUNT | Write data, one bit per pin |
| bus_rdata | output | PIN_COUNT | Registered read data |
| pad_in | input | PIN_COUNT | Pad input levels, asynchronous |
| pad_out | output | PIN_COUNT | Pad output levels, driven from the output latch |
| pad_oe | output | PIN_COUNT | Per-pin output enable, equal to the direction register |

## Verification
The bench builds the port with its default values: 32 pins, a 5-bit byte address and a two-stage synchronizer. The full pin width lets alternating, single-bit and all-ones patterns show that the set, clear and toggle aliases touch only the written bits. The 5-bit address leaves two unused word slots and the misaligned addresses within reach, so the bench can show that those slots are ignored. The two-stage depth fixes the exact edge at which a pad change first becomes readable, and the bench checks that edge.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  // Word indices (byte offset / 4). Software decodes these, so they are fixed.
  localparam int unsigned WORD_DATA = 0;
  localparam int unsigned WORD_SET  = 1;
  localparam int unsigned WORD_CLR  = 2;
  localparam int unsigned WORD_TGL  = 3;
  localparam int unsigned WORD_PIN  = 4;
  localparam int unsigned WORD_DIR  = 5;

  typedef struct packed {
    logic data;
    logic set;
    logic clr;
    logic tgl;
    logic pin;
    logic dir;
  } reg_sel_t;

endpackage

// File: rtl/gpio_port_rst_sync.sv
module gpio_port_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
    end else begin
      shift_q <= shift_d;
    end
  end

  assign rst_sync_n = shift_q[STAGES-1];

endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (g == 0) begin : g_first
      assign stage_d = async_i;
    end else begin : g_next
      assign stage_d = stage_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[g] <= '0;
      end else begin
        stage_q[g] <= stage_d;
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_port_decode.sv
module gpio_port_decode
  import gpio_port_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel
);

  localparam int unsigned WORD_W = ADDR_W - 2;

  logic              aligned;
  logic [WORD_W-1:0] word;

  always_comb begin
    aligned  = (addr[1:0] == 2'b00);
    word     = addr[ADDR_W-1:2];
    sel.data = aligned && (word == WORD_W'(WORD_DATA));
    sel.set  = aligned && (word == WORD_W'(WORD_SET));
    sel.clr  = aligned && (word == WORD_W'(WORD_CLR));
    sel.tgl  = aligned && (word == WORD_W'(WORD_TGL));
    sel.pin  = aligned && (word == WORD_W'(WORD_PIN));
    sel.dir  = aligned && (word == WORD_W'(WORD_DIR));
  end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  reg_sel_t         sel,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] latch_q,
  output logic [WIDTH-1:0] dir_q
);

  logic [WIDTH-1:0] latch_d;
  logic             latch_en;
  logic [WIDTH-1:0] dir_d;
  logic             dir_en;

  always_comb begin
    latch_en = wr_en && (sel.data || sel.set || sel.clr || sel.tgl);
    latch_d  = latch_q;
    if (sel.data) begin
      latch_d = wdata;
    end else if (sel.set) begin
      latch_d = latch_q | wdata;
    end else if (sel.clr) begin
      latch_d = latch_q & ~wdata;
    end else if (sel.tgl) begin
      latch_d = latch_q ^ wdata;
    end
    dir_en = wr_en && sel.dir;
    dir_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
    end else if (latch_en) begin
      latch_q <= latch_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
    end else if (dir_en) begin
      dir_q <= dir_d;
    end
  end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned PIN_COUNT   = 32,
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [PIN_COUNT-1:0] bus_wdata,
  output logic [PIN_COUNT-1:0] bus_rdata,
  input  logic [PIN_COUNT-1:0] pad_in,
  output logic [PIN_COUNT-1:0] pad_out,
  output logic [PIN_COUNT-1:0] pad_oe
);

  logic                 rst_sync_n;
  reg_sel_t             sel;
  logic [PIN_COUNT-1:0] latch_q;
  logic [PIN_COUNT-1:0] dir_q;
  logic [PIN_COUNT-1:0] pin_sync;
  logic [PIN_COUNT-1:0] rdata_d;
  logic [PIN_COUNT-1:0] rdata_q;
  logic                 rdata_en;

  gpio_port_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  gpio_port_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) u_pin_sync (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .async_i (pad_in),
    .sync_o  (pin_sync)
  );

  gpio_port_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (bus_addr),
    .sel  (sel)
  );

  gpio_port_regs #(.WIDTH(PIN_COUNT)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (bus_wr),
    .sel     (sel),
    .wdata   (bus_wdata),
    .latch_q (latch_q),
    .dir_q   (dir_q)
  );

  always_comb begin
    rdata_en = bus_rd;
    rdata_d  = '0;
    if (sel.data) begin
      rdata_d = latch_q;
    end else if (sel.pin) begin
      rdata_d = pin_sync;
    end else if (sel.dir) begin
      rdata_d = dir_q;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rdata_q <= '0;
    end else if (rdata_en) begin
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign pad_out   = latch_q;
  assign pad_oe    = dir_q;

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [WIDTH-1:0]  bus_wdata,
  input logic [WIDTH-1:0]  bus_rdata,
  input logic [WIDTH-1:0]  pad_out,
  input logic [WIDTH-1:0]  pad_oe
);

  logic [ADDR_W-1:0] a_data, a_set, a_clr, a_tgl, a_dir;
  logic              w_data, w_set, w_clr, w_tgl, w_dir, w_out;

  assign a_data = ADDR_W'(8'h00);
  assign a_set  = ADDR_W'(8'h04);
  assign a_clr  = ADDR_W'(8'h08);
  assign a_tgl  = ADDR_W'(8'h0C);
  assign a_dir  = ADDR_W'(8'h14);
  assign w_data = rst_n && bus_wr && (bus_addr == a_data);
  assign w_set  = rst_n && bus_wr && (bus_addr == a_set);
  assign w_clr  = rst_n && bus_wr && (bus_addr == a_clr);
  assign w_tgl  = rst_n && bus_wr && (bus_addr == a_tgl);
  assign w_dir  = rst_n && bus_wr && (bus_addr == a_dir);
  assign w_out  = w_data || w_set || w_clr || w_tgl;

  // R2
  p_data_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    w_data |=> pad_out == $past(bus_wdata));
  // R3
  p_set_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    w_set |=> pad_out == ($past(pad_out) | $past(bus_wdata)));
  // R4
  p_clr_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    w_clr |=> pad_out == ($past(pad_out) & ~$past(bus_wdata)));
  // R5
  p_tgl_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    w_tgl |=> pad_out == ($past(pad_out) ^ $past(bus_wdata)));
  // R7
  p_dir_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    w_dir |=> pad_oe == $past(bus_wdata));
  p_dir_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !w_dir |=> $stable(pad_oe));
  // R8
  p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !w_out |=> $stable(pad_out));
  // R9
  p_alias_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && bus_rd && (bus_addr == a_set || bus_addr == a_clr || bus_addr == a_tgl))
    |=> bus_rdata == '0);
  // R10
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

endmodule

bind gpio_port gpio_port_chk #(.WIDTH(PIN_COUNT), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe)
);

// File: tb/gpio_port_tb.sv
`timescale 1ns/1ps
module gpio_port_tb;

  localparam int unsigned W  = 32;
  localparam int unsigned AW = 5;

  logic          clk;
  logic          rst_n;
  logic          bus_wr;
  logic          bus_rd;
  logic [AW-1:0] bus_addr;
  logic [W-1:0]  bus_wdata;
  logic [W-1:0]  bus_rdata;
  logic [W-1:0]  pad_in;
  logic [W-1:0]  pad_out;
  logic [W-1:0]  pad_oe;

  int errors = 0;
  int checks = 0;
  bit done   = 0;
  logic [W-1:0] exp_out = '0;
  logic [W-1:0] exp_dir = '0;

  gpio_port #(.PIN_COUNT(W), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [W-1:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [W-1:0] r;
    check("R1 pad_out in reset", pad_out, '0);
    check("R1 pad_oe in reset", pad_oe, '0);
    check("R1 rdata in reset", bus_rdata, '0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    bus_read(5'h00, r); check("R1 data after reset", r, '0);
    bus_read(5'h14, r); check("R1 dir after reset", r, '0);
  endtask

  task automatic t_data();
    logic [W-1:0] r;
    bus_write(5'h00, 32'hA5A5_0F0F); exp_out = 32'hA5A5_0F0F;
    check("R8 pad_out after data write", pad_out, exp_out);
    bus_read(5'h00, r); check("R2 data readback", r, exp_out);
    bus_write(5'h00, 32'hFFFF_FFFF); exp_out = 32'hFFFF_FFFF;
    bus_read(5'h00, r); check("R2 data all ones", r, exp_out);
    bus_write(5'h00, 32'h0000_0000); exp_out = '0;
    check("R2 pad_out cleared by data write", pad_out, exp_out);
  endtask

  task automatic t_set();
    bus_write(5'h00, 32'h1234_5678); exp_out = 32'h1234_5678;
    bus_write(5'h04, 32'h8000_0001); exp_out |= 32'h8000_0001;
    check("R3 set two bits", pad_out, exp_out);
    bus_write(5'h04, 32'h0000_0000);
    check("R3 set with zero no change", pad_out, exp_out);
  endtask

  task automatic t_clr();
    bus_write(5'h08, 32'h1200_0078); exp_out &= ~32'h1200_0078;
    check("R4 clear selected bits", pad_out, exp_out);
    bus_write(5'h08, 32'hFFFF_FFFF); exp_out = '0;
    check("R4 clear all", pad_out, exp_out);
  endtask

  task automatic t_tgl();
    bus_write(5'h00, 32'hF0F0_F0F0); exp_out = 32'hF0F0_F0F0;
    bus_write(5'h0C, 32'hFF00_FF00); exp_out ^= 32'hFF00_FF00;
    check("R5 toggle pattern", pad_out, exp_out);
    bus_write(5'h0C, 32'hFF00_FF00); exp_out ^= 32'hFF00_FF00;
    check("R5 toggle back", pad_out, exp_out);
  endtask

  task automatic t_dir();
    logic [W-1:0] r;
    bus_write(5'h14, 32'h00FF_00FF); exp_dir = 32'h00FF_00FF;
    check("R7 pad_oe follows dir", pad_oe, exp_dir);
    bus_read(5'h14, r); check("R7 dir readback", r, exp_dir);
    bus_write(5'h04, 32'hFFFF_FFFF); exp_out = 32'hFFFF_FFFF;
    check("R7 oe unchanged by set write", pad_oe, exp_dir);
  endtask

  task automatic t_input();
    logic [W-1:0] r;
    pad_in = 32'h1111_1111;
    repeat (4) @(negedge clk);
    bus_read(5'h10, r); check("R6 input settled", r, 32'h1111_1111);
    // change pad and read with capture at 1st, 2nd, 3rd edge
    pad_in = 32'hCAFE_BABE;
    bus_rd = 1'b1; bus_addr = 5'h10;
    @(negedge clk); check("R6 first edge old", bus_rdata, 32'h1111_1111);
    @(negedge clk); check("R6 second edge old", bus_rdata, 32'h1111_1111);
    @(negedge clk); check("R6 third edge new", bus_rdata, 32'hCAFE_BABE);
    bus_rd = 1'b0;
    bus_write(5'h10, 32'h0000_0000);
    check("R6 input write leaves pad_out", pad_out, exp_out);
    check("R6 input write leaves pad_oe", pad_oe, exp_dir);
    bus_read(5'h10, r); check("R6 input unaffected by write", r, 32'hCAFE_BABE);
  endtask

  task automatic t_unmapped();
    logic [W-1:0] r;
    bus_read(5'h04, r); check("R9 set alias reads zero", r, '0);
    bus_read(5'h08, r); check("R9 clear alias reads zero", r, '0);
    bus_read(5'h0C, r); check("R9 toggle alias reads zero", r, '0);
    bus_write(5'h00, 32'h5555_AAAA); exp_out = 32'h5555_AAAA;
    bus_write(5'h18, 32'h0000_0000);
    bus_write(5'h1C, 32'h0000_0000);
    bus_write(5'h01, 32'h0000_0000);
    bus_write(5'h15, 32'hFFFF_FFFF);
    check("R9 unmapped writes leave pad_out", pad_out, exp_out);
    check("R9 unmapped writes leave pad_oe", pad_oe, exp_dir);
    bus_read(5'h18, r); check("R9 offset 0x18 reads zero", r, '0);
    bus_read(5'h1C, r); check("R9 offset 0x1C reads zero", r, '0);
    bus_read(5'h02, r); check("R9 misaligned reads zero", r, '0);
  endtask

  task automatic t_rd_hold();
    logic [W-1:0] r;
    bus_read(5'h00, r); check("R10 read data", r, exp_out);
    bus_write(5'h0C, 32'hFFFF_FFFF); exp_out = ~exp_out;
    repeat (2) @(negedge clk);
    check("R10 rdata holds without read", bus_rdata, ~exp_out);
    @(negedge clk);
    bus_rd = 1'b1; bus_wr = 1'b1; bus_addr = 5'h00; bus_wdata = 32'hDEAD_BEEF;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    check("R10 same-cycle read returns old", bus_rdata, exp_out);
    exp_out = 32'hDEAD_BEEF;
    check("R10 same-cycle write lands", pad_out, exp_out);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_addr = '0; bus_wdata = '0; pad_in = '0;
    repeat (3) @(negedge clk);
    t_reset();
    t_data();
    t_set();
    t_clr();
    t_tgl();
    t_dir();
    t_input();
    t_unmapped();
    t_rd_hold();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule